// File: doc/BRIEF.md
# Token routing crossbar

This block realises the edges of a dataflow graph that has been mapped one actor per functional unit. Every unit has a left operand buffer, a right operand buffer and a result buffer. The block owns all three banks. A unit fires when both of its operands are present and its result buffer is empty. The result is captured into the result buffer. A non-blocking crossbar then copies that token to every destination port named in the unit's route mask in the same cycle, and this can include the external output stream.

A configuration port sets up the graph before a run. It is usable only while `run_en` is low. For each node it loads an operation code, which is passed through to the unit unchanged, and a route mask. It also loads initial operand tokens, and it can bind an operand port to a constant. A constant port always counts as present and is never used up by a firing. Raising `run_en` starts token flow. Lowering it freezes every result buffer in place.

The external output is a valid/ready stream with a single-entry register. Once `out_valid` is high, the data and the source index hold steady until a cycle in which `out_ready` is high. While the register is full, any token that targets the external output waits in its result buffer.

Top module: `tok_xbar`

## Requirements
- R1: After reset no token is present in any bank, no unit fires, and `out_valid` is low.
- R2: Configuration writes made while `run_en` is high are ignored. They change no route, constant, opcode or token.
- R3: While `run_en` is high, node i fires (`fu_fire[i]`) when both of its operand ports are present and its result buffer is empty. `fu_a`/`fu_b` carry the operands, and `fu_res` is captured into the result buffer on that edge. A non-constant operand is consumed by the firing.
- R4: Route mask layout (width 2N+1): bit 2j selects the left port of node j, bit 2j+1 selects the right port of node j, and bit 2N selects the external output.
- R5: A result token moves only when every port in its mask is free. A free port is an empty, non-constant input buffer, or an empty external register. When it moves, all of its targets are written on the same edge and the result buffer is cleared. A token with any busy target stays where it is.
- R6: When the masks of several ready sources overlap, the lowest-indexed source wins. The other sources wait, so no port is ever written by two sources at once.
- R7: Configuration kinds on `cfg_kind` are: 0 = node opcode and route, 1 = initial left token, 2 = initial right token, 3 = constant left, 4 = constant right. A constant port is always present and survives any number of firings. An initial-token write removes a constant binding.
- R8: External stream: `out_data` and `out_src`, the index of the node that produced the token, stay stable while `out_valid` is high and `out_ready` is low. Each token is delivered exactly once.
- R9: While `run_en` is low, no unit fires and no result token moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High: token flow; low: configuration allowed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Write kind (see R7) |
| cfg_node | input | $clog2(N) | Target node |
| cfg_op | input | OPW | Opcode for kind 0 |
| cfg_route | input | 2N+1 | Route mask for kind 0 (see R4) |
| cfg_value | input | W | Token or constant value for kinds 1 to 4 |
| fu_fire | output | N | Per-node firing strobe |
| fu_op | output | N*OPW | Per-node opcode |
| fu_a | output | N*W | Per-node left operand |
| fu_b | output | N*W | Per-node right operand |
| fu_res | input | N*W | Per-node result from the units |
| out_valid | output | 1 | External token valid |
| out_ready | input | 1 | External consumer ready |
| out_data | output | W | External token value |
| out_src | output | $clog2(N) | Node that produced the external token |

## Verification
The assertions check the following on every cycle:
- no port ever has two writers;
- every target of a moved token is full right after the move;
- a firing always fills its result buffer;
- result buffers stay frozen while `run_en` is low;
- route and constant state stay fixed while writes are locked out;
- the output stream holds steady under back-pressure.

Other behaviours need the bench scenarios to show them:
- the arithmetic path through fan-out chains;
- a constant operand being reused across repeated waves;
- an atomic fan-out that stays blocked until a busy target drains;
- the order in which contending sources reach a shared port.

// File: rtl/tokxbar_pkg.sv
package tokxbar_pkg;
  typedef enum logic [2:0] {
    CK_NODE    = 3'd0,
    CK_INIT_L  = 3'd1,
    CK_INIT_R  = 3'd2,
    CK_CONST_L = 3'd3,
    CK_CONST_R = 3'd4
  } cfg_kind_e;
endpackage

// File: rtl/tok_bank.sv
// N-entry token buffer bank: a valid bit plus a data word per entry.
module tok_bank #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ld,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N*W-1:0] din,
  output logic [N-1:0] vld,
  output logic [N*W-1:0] dout
);
  logic [W-1:0] d_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int j = 0; j < N; j++) d_q[j] <= '0;
    end else begin
      for (int j = 0; j < N; j++) begin
        if (ld[j]) d_q[j] <= din[j*W +: W];
        if (set[j])      vld[j] <= 1'b1;
        else if (clr[j]) vld[j] <= 1'b0;
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    assign dout[j*W +: W] = d_q[j];
  end
endmodule

// File: rtl/node_cfg.sv
// Per-node opcode, route mask and constant bindings.
module node_cfg
  import tokxbar_pkg::*;
#(
  parameter int N   = 4,
  parameter int OPW = 4,
  parameter int RW  = 2*N+1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   sel,
  input  cfg_kind_e      kind,
  input  logic [OPW-1:0] op_in,
  input  logic [RW-1:0]  route_in,
  output logic [N*OPW-1:0] op_flat,
  output logic [N*RW-1:0]  route_flat,
  output logic [N-1:0]     const_l,
  output logic [N-1:0]     const_r
);
  logic [OPW-1:0] op_q    [N];
  logic [RW-1:0]  route_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      const_l <= '0;
      const_r <= '0;
      for (int j = 0; j < N; j++) begin
        op_q[j]    <= '0;
        route_q[j] <= '0;
      end
    end else begin
      for (int j = 0; j < N; j++) begin
        if (sel[j]) begin
          case (kind)
            CK_NODE: begin
              op_q[j]    <= op_in;
              route_q[j] <= route_in;
            end
            CK_INIT_L:  const_l[j] <= 1'b0;
            CK_INIT_R:  const_r[j] <= 1'b0;
            CK_CONST_L: const_l[j] <= 1'b1;
            CK_CONST_R: const_r[j] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_flat
    assign op_flat[j*OPW +: OPW]  = op_q[j];
    assign route_flat[j*RW +: RW] = route_q[j];
  end
endmodule

// File: rtl/route_arb.sv
// Fixed-priority all-or-nothing grant of result tokens to their target ports.
module route_arb #(
  parameter int N  = 4,
  parameter int RW = 2*N+1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    src_vld,
  input  logic [N*RW-1:0] route,
  input  logic [RW-1:0]   dst_busy,
  output logic [N-1:0]    grant,
  output logic [RW-1:0]   dst_wr
);
  logic [RW-1:0] claimed;
  logic [N-1:0]  wr_by [RW];

  always_comb begin
    claimed = dst_busy;
    grant   = '0;
    for (int i = 0; i < N; i++) begin
      if (src_vld[i] && (route[i*RW +: RW] != '0) &&
          ((route[i*RW +: RW] & claimed) == '0)) begin
        grant[i] = 1'b1;
        claimed  = claimed | route[i*RW +: RW];
      end
    end
  end

  assign dst_wr = claimed & ~dst_busy;

  always_comb begin
    for (int p = 0; p < RW; p++)
      for (int i = 0; i < N; i++)
        wr_by[p][i] = grant[i] & route[i*RW + p];
  end

  for (genvar p = 0; p < RW; p++) begin : g_chk
    // R6: at most one source drives any port in a cycle
    a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_by[p]));
  end
endmodule

// File: rtl/tok_xbar.sv
module tok_xbar
  import tokxbar_pkg::*;
#(
  parameter int N   = 4,
  parameter int W   = 16,
  parameter int OPW = 4,
  localparam int NW = $clog2(N),
  localparam int RW = 2*N+1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_kind,
  input  logic [NW-1:0]  cfg_node,
  input  logic [OPW-1:0] cfg_op,
  input  logic [RW-1:0]  cfg_route,
  input  logic [W-1:0]   cfg_value,
  output logic [N-1:0]   fu_fire,
  output logic [N*OPW-1:0] fu_op,
  output logic [N*W-1:0] fu_a,
  output logic [N*W-1:0] fu_b,
  input  logic [N*W-1:0] fu_res,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data,
  output logic [NW-1:0]  out_src
);
  cfg_kind_e kind;
  logic      cfg_ok;
  logic [N-1:0] sel;
  logic [N*RW-1:0] route_flat;
  logic [N-1:0] const_l, const_r;

  logic [N-1:0] ld_l, set_l, clr_l, vld_l;
  logic [N-1:0] ld_r, set_r, clr_r, vld_r;
  logic [N-1:0] vld_o, fire, grant;
  logic [N*W-1:0] din_l, din_r, od_flat;
  logic [RW-1:0] busy, dst_wr;
  logic [W-1:0]  rd [RW];
  logic [NW-1:0] ext_src_n;
  logic          ext_vld;
  logic [W-1:0]  ext_data;
  logic [NW-1:0] ext_src;

  assign kind   = cfg_kind_e'(cfg_kind);
  assign cfg_ok = cfg_we & ~run_en;

  node_cfg #(.N(N), .OPW(OPW), .RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sel(sel), .kind(kind),
    .op_in(cfg_op), .route_in(cfg_route),
    .op_flat(fu_op), .route_flat(route_flat),
    .const_l(const_l), .const_r(const_r)
  );

  for (genvar j = 0; j < N; j++) begin : g_node
    logic init_l, init_r, cst_l, cst_r;
    assign sel[j]  = cfg_ok && (cfg_node == NW'(j));
    assign init_l  = sel[j] && (kind == CK_INIT_L);
    assign init_r  = sel[j] && (kind == CK_INIT_R);
    assign cst_l   = sel[j] && (kind == CK_CONST_L);
    assign cst_r   = sel[j] && (kind == CK_CONST_R);

    assign set_l[j] = init_l | dst_wr[2*j];
    assign ld_l[j]  = init_l | cst_l | dst_wr[2*j];
    assign clr_l[j] = cst_l | (fire[j] & ~const_l[j]);
    assign set_r[j] = init_r | dst_wr[2*j+1];
    assign ld_r[j]  = init_r | cst_r | dst_wr[2*j+1];
    assign clr_r[j] = cst_r | (fire[j] & ~const_r[j]);

    assign din_l[j*W +: W] = run_en ? rd[2*j]   : cfg_value;
    assign din_r[j*W +: W] = run_en ? rd[2*j+1] : cfg_value;

    assign fire[j] = run_en & (vld_l[j] | const_l[j]) & (vld_r[j] | const_r[j]) & ~vld_o[j];

    assign busy[2*j]   = vld_l[j] | const_l[j];
    assign busy[2*j+1] = vld_r[j] | const_r[j];
  end
  assign busy[2*N] = ext_vld;

  tok_bank #(.N(N), .W(W)) u_left (
    .clk(clk), .rst_n(rst_n), .ld(ld_l), .set(set_l), .clr(clr_l),
    .din(din_l), .vld(vld_l), .dout(fu_a)
  );
  tok_bank #(.N(N), .W(W)) u_right (
    .clk(clk), .rst_n(rst_n), .ld(ld_r), .set(set_r), .clr(clr_r),
    .din(din_r), .vld(vld_r), .dout(fu_b)
  );
  tok_bank #(.N(N), .W(W)) u_result (
    .clk(clk), .rst_n(rst_n), .ld(fire), .set(fire), .clr(grant),
    .din(fu_res), .vld(vld_o), .dout(od_flat)
  );

  route_arb #(.N(N), .RW(RW)) u_arb (
    .clk(clk), .rst_n(rst_n), .src_vld(vld_o & {N{run_en}}),
    .route(route_flat), .dst_busy(busy), .grant(grant), .dst_wr(dst_wr)
  );

  // crossbar data paths: each port takes the word of its granted source
  always_comb begin
    ext_src_n = '0;
    for (int p = 0; p < RW; p++) begin
      rd[p] = '0;
      for (int i = 0; i < N; i++)
        if (grant[i] && route_flat[i*RW + p]) rd[p] = od_flat[i*W +: W];
    end
    for (int i = 0; i < N; i++)
      if (grant[i] && route_flat[i*RW + 2*N]) ext_src_n = NW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_vld  <= 1'b0;
      ext_data <= '0;
      ext_src  <= '0;
    end else if (dst_wr[2*N]) begin
      ext_vld  <= 1'b1;
      ext_data <= rd[2*N];
      ext_src  <= ext_src_n;
    end else if (out_ready) begin
      ext_vld  <= 1'b0;
    end
  end

  assign fu_fire   = fire;
  assign out_valid = ext_vld;
  assign out_data  = ext_data;
  assign out_src   = ext_src;

  // R8: stream holds under back-pressure
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_src)));

  // R9: result buffers frozen while stopped
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(vld_o));

  // R2: locked configuration keeps routes and bindings
  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cfg_we) |=> ($stable(route_flat) && $stable(const_l) && $stable(const_r)));

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    // R3: a firing fills the result buffer
    a_r3_fire_fills: assert property (@(posedge clk) disable iff (!rst_n)
      fire[gi] |=> vld_o[gi]);
    // R5: every target of a moved token is full afterwards
    a_r5_all_targets: assert property (@(posedge clk) disable iff (!rst_n)
      grant[gi] |=> ((busy & $past(route_flat[gi*RW +: RW])) == $past(route_flat[gi*RW +: RW])));
  end
endmodule

// File: tb/tok_xbar_test.sv
module tok_xbar_test;
  localparam int N = 4, W = 16, OPW = 4, NW = 2, RW = 9;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_kind = '0;
  logic [NW-1:0] cfg_node = '0;
  logic [OPW-1:0] cfg_op = '0;
  logic [RW-1:0] cfg_route = '0;
  logic [W-1:0] cfg_value = '0;
  logic [N-1:0] fu_fire;
  logic [N*OPW-1:0] fu_op;
  logic [N*W-1:0] fu_a, fu_b, fu_res;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic [NW-1:0] out_src;

  tok_xbar #(.N(N), .W(W), .OPW(OPW)) uut (.*);

  always #2.5 clk = ~clk;

  // functional unit stubs: adders
  always_comb
    for (int i = 0; i < N; i++) fu_res[i*W +: W] = fu_a[i*W +: W] + fu_b[i*W +: W];

  int nchk = 0, nfail = 0, cyc = 0;
  logic [W-1:0] got_d [16];
  int got_s [16];
  int ng, extra, fires_seen, hold_err, stalls;
  logic [W-1:0] exp_v [N];
  bit exp_on [N];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run_en = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input int kind, input int node, input int route, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_node = NW'(node);
    cfg_op = 4'h1; cfg_route = RW'(route); cfg_value = W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    extra = 0; fires_seen = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      out_ready = 1'b1;
      if (out_valid) extra++;
      if (fu_fire != '0) fires_seen++;
    end
  endtask

  task automatic collect(input int want, input int maxc, input bit rnd);
    bit prev_stall = 0;
    logic [W-1:0] pd = '0;
    logic [NW-1:0] ps = '0;
    ng = 0;
    for (int c = 0; c < maxc && ng < want; c++) begin
      @(negedge clk);
      if (prev_stall && (!out_valid || out_data != pd || out_src != ps)) hold_err++;
      out_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        got_d[ng] = out_data; got_s[ng] = int'(out_src); ng++;
      end
      prev_stall = out_valid && !out_ready;
      if (prev_stall) stalls++;
      pd = out_data; ps = out_src;
    end
  endtask

  task automatic check_set(input int want, input string req);
    bit seen [N];
    for (int s = 0; s < N; s++) seen[s] = 0;
    chk(ng == want, req, ng, want);
    for (int k = 0; k < ng; k++) begin
      int s = got_s[k];
      chk(exp_on[s] && !seen[s] && got_d[k] == exp_v[s], req, int'(got_d[k]), int'(exp_v[s]));
      seen[s] = 1;
    end
  endtask

  function automatic logic [W-1:0] add2(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    hold_err = 0; stalls = 0;
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(fu_fire == '0, "R1 fu_fire", int'(fu_fire), 0);

    // R2: writes while running are dropped
    run_en = 1'b1;
    cfg(1, 0, 0, 5); cfg(2, 0, 0, 6); cfg(0, 0, 9'h100, 0);
    idle(10);
    chk(extra == 0, "R2 no output from locked writes", extra, 0);
    chk(fires_seen == 0, "R2 no firing from locked writes", fires_seen, 0);
    @(negedge clk); run_en = 1'b0;

    // R9, R3, R4: single node to external output (bit 8)
    cfg(0, 0, 9'h100, 0); cfg(1, 0, 0, 5); cfg(2, 0, 0, 6);
    idle(5);
    chk(extra == 0 && fires_seen == 0, "R9 stopped holds tokens", extra + fires_seen, 0);
    run_en = 1'b1;
    collect(1, 30, 0);
    chk(ng == 1, "R3 one result", ng, 1);
    chk(got_d[0] == 16'd11, "R3 sum", int'(got_d[0]), 11);
    chk(got_s[0] == 0, "R4 external bit source", got_s[0], 0);
    idle(8);
    chk(extra == 0, "R3 operands consumed", extra, 0);

    // R5, R7, R8: fan-out with constants, random values and back-pressure
    do_reset();
    begin
      logic [W-1:0] k1, k2;
      k1 = W'($urandom); k2 = W'($urandom);
      cfg(0, 0, 9'h124, 0);           // n1.L (bit2), n2.R (bit5), ext (bit8)
      cfg(0, 1, 9'h100, 0); cfg(4, 1, 0, int'(k1));
      cfg(0, 2, 9'h100, 0); cfg(3, 2, 0, int'(k2));
      for (int it = 0; it < 4; it++) begin
        logic [W-1:0] a, b, s;
        a = W'($urandom); b = W'($urandom);
        if (it == 1) begin a = 16'hFFFF; b = 16'h0001; end
        s = add2(a, b);
        @(negedge clk); run_en = 1'b0;
        cfg(1, 0, 0, int'(a)); cfg(2, 0, 0, int'(b));
        exp_v[0] = s; exp_v[1] = add2(s, k1); exp_v[2] = add2(k2, s); exp_v[3] = '0;
        exp_on[0] = 1; exp_on[1] = 1; exp_on[2] = 1; exp_on[3] = 0;
        run_en = 1'b1;
        collect(3, 200, 1);
        check_set(3, "R7 R5 fan-out wave with constants");
        idle(4);
      end
    end

    // R5: fan-out blocked by one busy target
    do_reset();
    cfg(0, 0, 9'h014, 0);             // n1.L (bit2), n2.L (bit4)
    cfg(0, 1, 9'h100, 0); cfg(1, 1, 0, 7);
    cfg(0, 2, 9'h100, 0); cfg(4, 2, 0, 100);
    cfg(1, 0, 0, 20); cfg(2, 0, 0, 3);
    run_en = 1'b1;
    idle(12);
    chk(extra == 0, "R5 blocked fan-out moves nothing", extra, 0);
    @(negedge clk); run_en = 1'b0;
    cfg(2, 1, 0, 9);
    exp_v[0] = '0; exp_v[1] = 16'd16; exp_v[2] = 16'd123; exp_v[3] = '0;
    exp_on[0] = 0; exp_on[1] = 1; exp_on[2] = 1; exp_on[3] = 0;
    run_en = 1'b1;
    collect(2, 100, 1);
    check_set(2, "R5 fan-out after drain");
    idle(10);
    chk(extra == 0, "R5 n1 waits for right operand", extra, 0);

    // R6: two sources contend for n3.L (bit6); lower index first
    do_reset();
    cfg(0, 0, 9'h040, 0); cfg(0, 1, 9'h040, 0);
    cfg(0, 3, 9'h100, 0); cfg(4, 3, 0, 0);
    cfg(1, 0, 0, 10); cfg(2, 0, 0, 1);
    cfg(1, 1, 0, 30); cfg(2, 1, 0, 2);
    run_en = 1'b1;
    collect(2, 60, 0);
    chk(ng == 2, "R6 both delivered", ng, 2);
    chk(got_d[0] == 16'd11 && got_s[0] == 3, "R6 lower index first", int'(got_d[0]), 11);
    chk(got_d[1] == 16'd32 && got_s[1] == 3, "R6 higher index second", int'(got_d[1]), 32);

    // R8: stream stability under back-pressure
    chk(hold_err == 0, "R8 hold under stall", hold_err, 0);
    chk(stalls > 0, "R8 stalls exercised", stalls, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule